// File: doc/BRIEF.md
# DMA Request Router

This block sits between a set of peripheral request lines and the channels of a DMA engine. Software programs one routing entry per request line; each entry carries an enable bit and a channel number, so any number of request lines may share one channel while an unrouted line has no effect. The block keeps, per channel, a request-active level that follows whichever routed line changed most recently. It emits one-cycle strobes that the channel status logic consumes: an arrival strobe when a routed line goes high while its channel is idle, and an end-of-receive strobe when a routed line goes low while its channel is active.

Request inputs are asynchronous and pass through a synchronizer. A channel handles at most one line change per clock. When several lines routed to the same channel change together, the lowest-numbered line is handled first and the rest are handled on later clocks, so no change is lost. The routing entries are reached through a 32-bit register port whose read data is combinational. The entries sit in two address windows: a low window for the first 64 lines and a high window for the rest.

Top module: `dmr_req_router`

## Requirements
- R1: A routing entry keeps write-data bit 7 as its enable bit and bits 4:0 as its channel number. A read returns those bits in the same positions and returns zeros in every other bit.
- R2: Line n below 64 has its entry at byte offset 0x100 + 4·n. Line n from 64 up has its entry at 0x1100 + 4·(n−64). A read of any other offset, of a misaligned offset, or of a slot past the last line returns zero, and a write there changes no entry.
- R3: After reset every entry reads zero. Every channel level and every strobe is low.
- R4: A line whose entry has the enable bit clear changes no channel level and produces no strobe.
- R5: A routed line that rises while its channel level is low produces exactly one arrival strobe and sets the level. Both appear three clocks after the input change: two synchronizer stages plus one output register.
- R6: A routed line that falls while its channel level is high produces exactly one end-of-receive strobe and clears the level.
- R7: A routed change that leaves the level where it was produces no strobe. This covers a rise while the level is high and a fall while it is low. The level always takes the value of the most recently handled line.
- R8: Each channel handles at most one change per clock. Among simultaneous changes on one channel, the lowest line number is handled first, and each later change is handled on the following clock.
- R9: A write with bit 7 set and a channel number at or above the channel count raises the error output for one clock and leaves the entry unchanged. A write with bit 7 clear is always stored.
- R10: Enabling the entry of a line that is already high produces no strobe. The line's next change is handled normally.
- R11: Different channels handle their changes in the same clock, independently of each other. No channel ever shows both strobes in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| reg_err | output | 1 | One-clock pulse after a rejected channel number |
| req_in | input | NUM_REQ | Asynchronous peripheral request lines |
| ch_req_lvl | output | NUM_CH | Request-active level per channel |
| ch_arrive | output | NUM_CH | Arrival strobe per channel |
| ch_eor | output | NUM_CH | End-of-receive strobe per channel |

## Verification
The bench builds the block with 75 request lines, so both address windows and the slot just past the high window can be reached. It uses 8 channels instead of 32, which brings the rejection of a valid entry with an out-of-range channel number within reach; with 32 channels every 5-bit number is legal. Sharing one channel between two lines gives the ordering and level-follows-latest cases.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
    localparam int CH_FIELD_W = 5;
    localparam int ENABLE_BIT = 7;

    typedef struct packed {
        logic                  en;
        logic [CH_FIELD_W-1:0] ch;
    } route_ent_t;
endpackage

// File: rtl/dmr_req_sync.sv
module dmr_req_sync #(
    parameter int WIDTH  = 75,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dmr_route_regs.sv
module dmr_route_regs
    import dmr_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 32,
    parameter int ADDR_W  = 16,
    parameter int LO_BASE = 'h100,
    parameter int HI_BASE = 'h1100
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr_en_bit,
    input  logic [CH_FIELD_W-1:0]      wr_ch,
    output logic [31:0]                rdata,
    output logic                       err,
    output route_ent_t [NUM_REQ-1:0]   table_o
);
    localparam int LO_COUNT = (NUM_REQ < 64) ? NUM_REQ : 64;
    localparam int HI_COUNT = NUM_REQ - LO_COUNT;
    localparam int IDX_W    = $clog2(NUM_REQ);

    typedef struct packed {
        route_ent_t [NUM_REQ-1:0] ent;
        logic                     err;
    } regs_t;

    regs_t            st_d, st_q;
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [ADDR_W-1:0] lo_off, hi_off;

    always_comb begin
        lo_off = addr - ADDR_W'(LO_BASE);
        hi_off = addr - ADDR_W'(HI_BASE);
        hit    = 1'b0;
        idx    = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr >= ADDR_W'(LO_BASE) && lo_off < ADDR_W'(LO_COUNT * 4)) begin
                hit = 1'b1;
                idx = lo_off[IDX_W+1:2];
            end else if (HI_COUNT > 0 && addr >= ADDR_W'(HI_BASE) &&
                         hi_off < ADDR_W'(HI_COUNT * 4)) begin
                hit = 1'b1;
                idx = IDX_W'(LO_COUNT) + hi_off[IDX_W+1:2];
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (wr_en && hit) begin
            if (wr_en_bit && int'(wr_ch) >= NUM_CH) begin
                st_d.err = 1'b1;
            end else begin
                st_d.ent[idx].en = wr_en_bit;
                st_d.ent[idx].ch = wr_ch;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[ENABLE_BIT]       = st_q.ent[idx].en;
            rdata[CH_FIELD_W-1:0]   = st_q.ent[idx].ch;
        end
    end

    assign err     = st_q.err;
    assign table_o = st_q.ent;

    // R9: a rejected write leaves the whole table as it was
    a_r9_reject_keeps_table: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> st_q.ent == $past(st_q.ent));

    // R9: the error pulse only follows a write
    a_r9_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> $past(wr_en));

    // R9: no enabled entry ever holds an out-of-range channel
    always_comb begin
        for (int r = 0; r < NUM_REQ; r++) begin
            a_r9_legal_channel: assert (!rst_n || !st_q.ent[r].en ||
                                        int'(st_q.ent[r].ch) < NUM_CH);
        end
    end
endmodule

// File: rtl/dmr_chan_track.sv
module dmr_chan_track
    import dmr_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_REQ-1:0]       req_s,
    input  route_ent_t [NUM_REQ-1:0] table_i,
    output logic [NUM_CH-1:0]        lvl_o,
    output logic [NUM_CH-1:0]        arrive_o,
    output logic [NUM_CH-1:0]        eor_o
);
    typedef struct packed {
        logic [NUM_REQ-1:0] seen;
        logic [NUM_CH-1:0]  lvl;
        logic [NUM_CH-1:0]  arrive;
        logic [NUM_CH-1:0]  eor;
    } track_t;

    track_t                           st_d, st_q;
    logic [NUM_REQ-1:0]               enabled, pending;
    logic [NUM_CH-1:0][NUM_REQ-1:0]   pick;

    always_comb begin
        for (int r = 0; r < NUM_REQ; r++) enabled[r] = table_i[r].en;
        pending = (req_s ^ st_q.seen) & enabled;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [NUM_REQ-1:0] cand;
        always_comb begin
            for (int r = 0; r < NUM_REQ; r++) begin
                cand[r] = pending[r] && (table_i[r].ch == CH_FIELD_W'(c));
            end
        end
        // isolate the lowest-numbered candidate
        assign pick[c] = cand & (~cand + NUM_REQ'(1));
    end

    always_comb begin
        logic [NUM_REQ-1:0] granted;
        logic               chg, nlvl;
        st_d    = st_q;
        granted = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            granted        = granted | pick[c];
            chg            = |pick[c];
            nlvl           = |(pick[c] & req_s);
            st_d.arrive[c] = chg && nlvl && !st_q.lvl[c];
            st_d.eor[c]    = chg && !nlvl && st_q.lvl[c];
            if (chg) st_d.lvl[c] = nlvl;
        end
        for (int r = 0; r < NUM_REQ; r++) begin
            if (!enabled[r] || granted[r]) st_d.seen[r] = req_s[r];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o    = st_q.lvl;
    assign arrive_o = st_q.arrive;
    assign eor_o    = st_q.eor;

    // R11: the two strobes never coincide on a channel
    a_r11_no_double_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.arrive & st_q.eor) == '0);

    // R5: an arrival strobe marks a low-to-high step of the level
    a_r5_arrive_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.arrive & ~st_q.lvl) | (st_q.arrive & $past(st_q.lvl))) == '0);

    // R6: an end-of-receive strobe marks a high-to-low step of the level
    a_r6_eor_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.eor & st_q.lvl) | (st_q.eor & ~$past(st_q.lvl))) == '0);

    // R7: the level never moves without a strobe
    a_r7_level_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.lvl ^ $past(st_q.lvl)) & ~(st_q.arrive | st_q.eor)) == '0);

    // R8: at most one line is handled per channel per clock
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            a_r8_one_per_channel: assert (!rst_n || $onehot0(pick[c]));
        end
    end
endmodule

// File: rtl/dmr_req_router.sv
module dmr_req_router
    import dmr_pkg::*;
#(
    parameter int NUM_REQ     = 75,
    parameter int NUM_CH      = 32,
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               reg_err,
    input  logic [NUM_REQ-1:0] req_in,
    output logic [NUM_CH-1:0]  ch_req_lvl,
    output logic [NUM_CH-1:0]  ch_arrive,
    output logic [NUM_CH-1:0]  ch_eor
);
    logic [NUM_REQ-1:0]       req_s;
    route_ent_t [NUM_REQ-1:0] route_tbl;
    logic                     unused_wdata;

    assign unused_wdata = ^{reg_wdata[31:ENABLE_BIT+1], reg_wdata[ENABLE_BIT-1:CH_FIELD_W]};

    dmr_req_sync #(.WIDTH(NUM_REQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(req_in),
        .sync_o (req_s)
    );

    dmr_route_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wr_en_bit(reg_wdata[ENABLE_BIT]),
        .wr_ch    (reg_wdata[CH_FIELD_W-1:0]),
        .rdata    (reg_rdata),
        .err      (reg_err),
        .table_o  (route_tbl)
    );

    dmr_chan_track #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_s   (req_s),
        .table_i (route_tbl),
        .lvl_o   (ch_req_lvl),
        .arrive_o(ch_arrive),
        .eor_o   (ch_eor)
    );
endmodule

// File: tb/tb_dmr_req_router.sv
module tb_dmr_req_router;
    localparam int NREQ = 75;
    localparam int NCH  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [15:0]     reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            reg_err;
    logic [NREQ-1:0] req_in = '0;
    logic [NCH-1:0]  ch_req_lvl, ch_arrive, ch_eor;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dmr_req_router #(.NUM_REQ(NREQ), .NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
        .req_in(req_in), .ch_req_lvl(ch_req_lvl), .ch_arrive(ch_arrive), .ch_eor(ch_eor)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // write one entry; returns the error output seen after the write edge
    task automatic wr_reg(input logic [15:0] a, input logic [31:0] d, output logic e);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        e = reg_err;
    endtask

    task automatic rd_reg(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // change lines at a falling edge, then stop between the 3rd and 4th rising edge
    task automatic drive_and_settle(input logic [NREQ-1:0] v);
        @(negedge clk);
        req_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    // watch n cycles and accumulate any strobe
    task automatic watch(input int n, output logic [NCH-1:0] a_acc, output logic [NCH-1:0] e_acc);
        a_acc = '0; e_acc = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            a_acc |= ch_arrive; e_acc |= ch_eor;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R3 level after reset", 32'(ch_req_lvl), 0);
        chk("R3 strobes after reset", 32'(ch_arrive | ch_eor), 0);
        rd_reg(16'h100, d);  chk("R3 low entry after reset", d, 0);
        rd_reg(16'h1128, d); chk("R3 high entry after reset", d, 0);
    endtask

    task automatic t_format;
        logic [31:0] d; logic e;
        wr_reg(16'h10C, 32'hFFFF_FFE2, e);          // line 3 -> ch 2, junk bits
        rd_reg(16'h10C, d);  chk("R1 readback keeps bits 7 and 4:0", d, 32'h82);
        wr_reg(16'h1118, 32'h85, e);                // line 70 -> ch 5
        rd_reg(16'h1118, d); chk("R2 high window slot 70", d, 32'h85);
        wr_reg(16'h1130, 32'h81, e);                // past line 74
        rd_reg(16'h1130, d); chk("R2 slot past last line reads zero", d, 0);
        rd_reg(16'h1128, d); chk("R2 last line untouched", d, 0);
        wr_reg(16'h00A0, 32'h81, e);
        rd_reg(16'h00A0, d); chk("R2 offset outside windows reads zero", d, 0);
        rd_reg(16'h10D, d);  chk("R2 misaligned read is zero", d, 0);
        rd_reg(16'h10C, d);  chk("R2 line 3 kept its entry", d, 32'h82);
    endtask

    task automatic t_bad_channel;
        logic [31:0] d; logic e;
        wr_reg(16'h110, 32'h83, e);                 // line 4 -> ch 3
        chk("R9 legal write no error", 32'(e), 0);
        wr_reg(16'h110, 32'h8A, e);                 // ch 10 >= 8
        chk("R9 error on out-of-range channel", 32'(e), 1);
        rd_reg(16'h110, d); chk("R9 entry unchanged", d, 32'h83);
        @(negedge clk); chk("R9 error lasts one clock", 32'(reg_err), 0);
        wr_reg(16'h110, 32'h0A, e);                 // disabled, stored
        chk("R9 disabled write no error", 32'(e), 0);
        rd_reg(16'h110, d); chk("R9 disabled entry stored", d, 32'h0A);
    endtask

    task automatic t_unrouted;
        logic [NCH-1:0] a, e;
        req_in[4] = 1'b1; req_in[9] = 1'b1;
        watch(6, a, e);
        chk("R4 disabled lines give no arrival", 32'(a), 0);
        chk("R4 disabled lines give no level", 32'(ch_req_lvl), 0);
        req_in[4] = 1'b0; req_in[9] = 1'b0;
        watch(6, a, e);
        chk("R4 disabled lines give no end strobe", 32'(e), 0);
    endtask

    task automatic t_rise_fall;
        logic [NREQ-1:0] v;
        v = req_in; v[3] = 1'b1;
        @(negedge clk); req_in = v;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R5 no strobe before third clock", 32'(ch_arrive), 0);
        @(negedge clk);
        chk("R5 arrival strobe on ch2", 32'(ch_arrive), 32'h04);
        chk("R5 level set on ch2", 32'(ch_req_lvl), 32'h04);
        @(negedge clk);
        chk("R5 arrival lasts one clock", 32'(ch_arrive), 0);
        v[3] = 1'b0; drive_and_settle(v);
        chk("R6 end strobe on ch2", 32'(ch_eor), 32'h04);
        chk("R6 level cleared", 32'(ch_req_lvl), 0);
        @(negedge clk);
        chk("R6 end strobe lasts one clock", 32'(ch_eor), 0);
    endtask

    task automatic t_shared;
        logic [NREQ-1:0] v; logic [NCH-1:0] a, e; logic er;
        wr_reg(16'h114, 32'h82, er);                // line 5 -> ch 2
        v = req_in; v[3] = 1'b1; drive_and_settle(v);
        chk("R5 line 3 arrival", 32'(ch_arrive), 32'h04);
        v[5] = 1'b1;
        @(negedge clk); req_in = v;
        watch(6, a, e);
        chk("R7 rise while active no strobe", 32'(a | e), 0);
        chk("R7 level stays high", 32'(ch_req_lvl), 32'h04);
        v[3] = 1'b0; drive_and_settle(v);
        chk("R7 latest change wins: end strobe", 32'(ch_eor), 32'h04);
        chk("R7 level follows latest change", 32'(ch_req_lvl), 0);
        v[5] = 1'b0;
        @(negedge clk); req_in = v;
        watch(6, a, e);
        chk("R7 fall while idle no strobe", 32'(a | e), 0);
        v[3] = 1'b1; drive_and_settle(v);
        chk("R8 setup arrival", 32'(ch_arrive), 32'h04);
        v[3] = 1'b0; v[5] = 1'b1; drive_and_settle(v);
        chk("R8 lower line first: end strobe", 32'(ch_eor), 32'h04);
        chk("R8 lower line first: no arrival yet", 32'(ch_arrive), 0);
        chk("R8 level low after first", 32'(ch_req_lvl), 0);
        @(negedge clk);
        chk("R8 next clock: arrival", 32'(ch_arrive), 32'h04);
        chk("R8 next clock: level high", 32'(ch_req_lvl), 32'h04);
    endtask

    task automatic t_independent;
        logic [NREQ-1:0] v;
        v = req_in; v[5] = 1'b0; v[70] = 1'b1; drive_and_settle(v);
        chk("R11 ch2 end strobe same clock", 32'(ch_eor), 32'h04);
        chk("R11 ch5 arrival same clock", 32'(ch_arrive), 32'h20);
        chk("R11 levels", 32'(ch_req_lvl), 32'h20);
    endtask

    task automatic t_enable_while_high;
        logic [NREQ-1:0] v; logic [NCH-1:0] a, e; logic er;
        v = req_in; v[6] = 1'b1; drive_and_settle(v);
        wr_reg(16'h118, 32'h83, er);                // line 6 -> ch 3
        watch(6, a, e);
        chk("R10 enabling a high line: no strobe", 32'(a | e), 0);
        chk("R10 ch3 level untouched", 32'(ch_req_lvl & 8'h08), 0);
        v[6] = 1'b0;
        @(negedge clk); req_in = v;
        watch(6, a, e);
        chk("R10 later fall on idle channel: no strobe", 32'(a | e), 0);
        v[6] = 1'b1; drive_and_settle(v);
        chk("R10 next rise handled", 32'(ch_arrive), 32'h08);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_format();
        t_bad_channel();
        t_unrouted();
        t_rise_fall();
        t_shared();
        t_independent();
        t_enable_while_high();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        checks++; errors++;
        $display("FAIL watchdog R1-all: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule